// File: doc/BRIEF.md
# UART Modem Status Tracker

This block builds the modem status byte of a 16550-style serial port. It watches four active-low modem lines (carrier detect, ring indicator, data set ready, clear to send). It shows their present asserted state in the upper nibble of the byte. The lower nibble holds sticky change flags, and any register read clears them. While at least one change flag is set and the enable input is high, the block raises a modem-status interrupt request.

Each pin passes through a synchronizer first. In loopback mode the four lines come from the modem-control register bits instead of the pins, so software can exercise the status path without outside wiring. The line history resets to the de-asserted level. As a result, a line that is held asserted through reset reports a change once reset ends. Bus decoding and interrupt priority belong to the surrounding port logic.

Top module: `modem_status_tracker`

## Requirements
- R1: Outside loopback, bits 7, 6, 5 and 4 of the read data show the inverse of the synchronized carrier detect, ring, data set ready and clear to send pins. A low pin reads as 1.
- R2: Bits 3 (carrier detect), 1 (data set ready) and 0 (clear to send) become 1 on any transition of the line's asserted state and stay 1 until cleared.
- R3: Bit 2 becomes 1 only when the ring line goes from asserted to de-asserted. Its leading edge leaves bit 2 unchanged.
- R4: A cycle with the read strobe high clears bits 3 to 0 at the next clock edge. The read data in that cycle still shows the flags as they were before the clear.
- R5: With loopback high, the lines come from the control bits: carrier detect from control bit 3, ring from control bit 2, data set ready from control bit 0 and clear to send from control bit 1. A 1 means asserted. The status appears one clock edge after a control bit changes, and change flags follow these sources.
- R6: In loopback, control bit 2 falling from 1 to 0 sets bit 2.
- R7: A carrier detect, data set ready or clear to send pin held low through reset sets its change flag on the third clock edge after reset release. A ring pin held low through reset sets nothing.
- R8: The interrupt output is high exactly when the interrupt enable is high and any of bits 3 to 0 is 1.
- R9: Bits 31 to 8 always read 0. During reset, with loopback low, the whole word and the interrupt output are 0.
- R10: A change detected at the same edge as a clearing read sets its flag, so the event is kept.
- R11: Pins pass through two synchronizer flops. A pin change made before clock edge k shows in the status at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinCarrierN | input | 1 | Carrier detect pin, active low |
| pinRingN | input | 1 | Ring indicator pin, active low |
| pinReadyN | input | 1 | Data set ready pin, active low |
| pinClearN | input | 1 | Clear to send pin, active low |
| loopEn | input | 1 | Loopback mode select |
| ctrlBits | input | 4 | Modem-control outputs used as sources in loopback |
| readStrobe | input | 1 | Status register read in this cycle |
| intEnable | input | 1 | Modem-status interrupt enable |
| readData | output | 32 | Status register read data |
| irq | output | 1 | Modem-status interrupt request |

## Verification
If the line history is wrong, a change flag shows up one edge after a transition that should not set it, or fails to show up at all. A missing or extra synchronizer stage moves the status nibble by one edge relative to the pin change. A clear that is too strong or too weak shows in the read data on the cycle after a read. That is also where a lost set/clear collision appears. Interrupt errors show at once, in the same cycle as the flag or enable change.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int unsigned LINE_COUNT = 4;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned PAD_W      = DATA_W - 2 * LINE_COUNT;

  // line index equals change-flag bit position
  localparam int unsigned LN_CLEAR   = 0;
  localparam int unsigned LN_READY   = 1;
  localparam int unsigned LN_RING    = 2;
  localparam int unsigned LN_CARRIER = 3;

  typedef logic [LINE_COUNT-1:0] lineVec_t;

  typedef struct packed {
    logic clearFlags;
  } mstStrobe_t;

  // control-register bit feeding each line in loopback
  function automatic int unsigned loopSrcBit(int unsigned line);
    case (line)
      LN_CLEAR: return 1;
      LN_READY: return 0;
      LN_RING:  return 2;
      default:  return 3;
    endcase
  endfunction
endpackage

// File: rtl/mst_sync.sv
module mst_sync #(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= {STAGES{RESET_VAL}};
      else       chainQ <= {chainQ[STAGES-2:0], dIn[g]};
    end
    assign dOut[g] = chainQ[STAGES-1];
  end
endmodule

// File: rtl/mst_ctrl.sv
module mst_ctrl
  import mst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       readStrobe,
  input  logic       intEnable,
  input  lineVec_t   flags,
  output mstStrobe_t strb,
  output logic       irq
);
  always_comb begin
    strb = '0;
    strb.clearFlags = readStrobe;
  end

  assign irq = intEnable && (flags != '0);

  // irq can only rise while the enable is set
  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> intEnable);
  // with the enable low the request never shows, whatever the flags
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> !irq);
endmodule

// File: rtl/mst_datapath.sv
module mst_datapath
  import mst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lineVec_t   syncPinsN,
  input  logic       loopEn,
  input  logic [3:0] ctrlBits,
  input  mstStrobe_t strb,
  output lineVec_t   levels,
  output lineVec_t   flags
);
  lineVec_t srcNow;
  lineVec_t lvlQ;
  lineVec_t setVec;
  lineVec_t flagQ;

  for (genvar g = 0; g < LINE_COUNT; g++) begin : g_line
    assign srcNow[g] = loopEn ? ctrlBits[loopSrcBit(g)] : ~syncPinsN[g];
    if (g == LN_RING) begin : g_trail
      assign setVec[g] = lvlQ[g] & ~srcNow[g];
    end else begin : g_any
      assign setVec[g] = lvlQ[g] ^ srcNow[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ  <= '0;
      flagQ <= '0;
    end else begin
      lvlQ  <= srcNow;
      flagQ <= (strb.clearFlags ? '0 : flagQ) | setVec;
    end
  end

  assign levels = lvlQ;
  assign flags  = flagQ;

  p_pin_level_r1: assert property (@(posedge clk) disable iff (!rstN)
    !loopEn |=> levels == ~$past(syncPinsN));
  p_delta_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(levels[LN_CLEAR]) != levels[LN_CLEAR]) |-> flags[LN_CLEAR]);
  p_delta_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(levels[LN_READY]) != levels[LN_READY]) |-> flags[LN_READY]);
  p_delta_carrier_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(levels[LN_CARRIER]) != levels[LN_CARRIER]) |-> flags[LN_CARRIER]);
  p_ring_trailing_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[LN_RING]) |-> ($past(levels[LN_RING]) && !levels[LN_RING]));
  p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearFlags && setVec == '0) |=> flags == '0);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearFlags |=> ((flags & $past(flags)) == $past(flags)));
  p_loop_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |=> (levels[LN_CARRIER] == $past(ctrlBits[3]) &&
                levels[LN_RING]    == $past(ctrlBits[2]) &&
                levels[LN_CLEAR]   == $past(ctrlBits[1]) &&
                levels[LN_READY]   == $past(ctrlBits[0])));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearFlags && setVec != '0) |=> ((flags & $past(setVec)) == $past(setVec)));
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import mst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinCarrierN,
  input  logic        pinRingN,
  input  logic        pinReadyN,
  input  logic        pinClearN,
  input  logic        loopEn,
  input  logic [3:0]  ctrlBits,
  input  logic        readStrobe,
  input  logic        intEnable,
  output logic [31:0] readData,
  output logic        irq
);
  lineVec_t   rawPinsN;
  lineVec_t   syncPinsN;
  lineVec_t   levels;
  lineVec_t   flags;
  mstStrobe_t strb;

  always_comb begin
    rawPinsN              = '1;
    rawPinsN[LN_CLEAR]    = pinClearN;
    rawPinsN[LN_READY]    = pinReadyN;
    rawPinsN[LN_RING]     = pinRingN;
    rawPinsN[LN_CARRIER]  = pinCarrierN;
  end

  mst_sync #(.WIDTH(LINE_COUNT), .STAGES(SYNC_DEPTH), .RESET_VAL(1'b1)) u_sync (
    .clk (clk), .rstN (rstN), .dIn (rawPinsN), .dOut (syncPinsN)
  );

  mst_ctrl u_ctrl (
    .clk (clk), .rstN (rstN), .readStrobe (readStrobe), .intEnable (intEnable),
    .flags (flags), .strb (strb), .irq (irq)
  );

  mst_datapath u_dp (
    .clk (clk), .rstN (rstN), .syncPinsN (syncPinsN), .loopEn (loopEn),
    .ctrlBits (ctrlBits), .strb (strb), .levels (levels), .flags (flags)
  );

  assign readData = {{PAD_W{1'b0}}, levels, flags};

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |-> readData[DATA_W-1:2*LINE_COUNT] == '0);
endmodule

// File: tb/modem_status_tracker_tb.sv
`timescale 1ns/1ps
module modem_status_tracker_tb;
  localparam real CYC = 4.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinCarrierN = 1'b1, pinRingN = 1'b1, pinReadyN = 1'b1, pinClearN = 1'b1;
  logic loopEn = 1'b0;
  logic [3:0] ctrlBits = 4'h0;
  logic readStrobe = 1'b0;
  logic intEnable = 1'b0;
  logic [31:0] readData;
  logic irq;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  string phaseTag = "R9";

  always #(CYC/2) clk = ~clk;

  modem_status_tracker u_dut (
    .clk, .rstN, .pinCarrierN, .pinRingN, .pinReadyN, .pinClearN,
    .loopEn, .ctrlBits, .readStrobe, .intEnable, .readData, .irq
  );

  // reference built from the requirements: two pin delays, then line state
  logic [3:0] m1, m2, mLvl, mFlg;

  function automatic logic [3:0] srcOf(logic lp, logic [3:0] c, logic [3:0] p2);
    return lp ? {c[3], c[2], c[0], c[1]} : ~p2;
  endfunction

  function automatic logic [3:0] setOf(logic [3:0] prev, logic [3:0] nw);
    logic [3:0] s;
    s = prev ^ nw;
    s[2] = prev[2] & ~nw[2];
    return s;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 4'hF; m2 <= 4'hF; mLvl <= 4'h0; mFlg <= 4'h0;
    end else begin
      mFlg <= (readStrobe ? 4'h0 : mFlg) | setOf(mLvl, srcOf(loopEn, ctrlBits, m2));
      mLvl <= srcOf(loopEn, ctrlBits, m2);
      m2 <= m1;
      m1 <= {pinCarrierN, pinRingN, pinReadyN, pinClearN};
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmpModel();
    chk(phaseTag, readData, {24'h0, mLvl, mFlg});
    chk({phaseTag, " R8 irq"}, {31'h0, irq}, {31'h0, intEnable & (mFlg != 0)});
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmpModel();
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  endtask

  initial begin
    #(CYC * 150000);
    failCnt++; checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'h5EED));
    // R9: reset state with pins asserted (also sets up R7)
    pinCarrierN = 0; pinRingN = 0; pinReadyN = 0; pinClearN = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset word", readData, 32'h0);
    chk("R9 reset irq", {31'h0, irq}, 32'h0);
    rstN = 1'b1;
    phaseTag = "R7/R11";
    step(2);
    chk("R11 not yet visible", readData, 32'h0);
    step(1);
    chk("R7 held-through-reset flags", readData, 32'hFB);
    // R4: read returns old flags, clears them
    readStrobe = 1; phaseTag = "R4";
    chk("R4 pre-clear value", readData, 32'hFB);
    step(1);
    readStrobe = 0;
    chk("R4 cleared", readData, 32'hF0);
    // R3: ring trailing edge sets, leading edge does not
    phaseTag = "R3"; pinRingN = 1;
    step(3);
    chk("R3 trailing edge", readData, 32'hB4);
    readStrobe = 1; step(1); readStrobe = 0;
    pinRingN = 0;
    step(4);
    chk("R3 leading edge ignored", readData, 32'hF0);
    // R2 / R8
    phaseTag = "R2"; intEnable = 1; pinClearN = 1;
    step(3);
    chk("R2 clear-to-send delta", readData, 32'hE1);
    chk("R8 irq on", {31'h0, irq}, 32'h1);
    intEnable = 0; #0.1;
    chk("R8 irq gated", {31'h0, irq}, 32'h0);
    readStrobe = 1; step(1); readStrobe = 0;
    // R10: change lands at the clearing edge
    phaseTag = "R10"; pinCarrierN = 1;
    step(2);
    readStrobe = 1;
    step(1);
    readStrobe = 0;
    chk("R10 set beats clear", readData, 32'h68);
    readStrobe = 1; step(1); readStrobe = 0;
    // R5 / R6 loopback
    phaseTag = "R5"; loopEn = 1; ctrlBits = 4'b0100;
    step(1);
    chk("R5 loop ring from ctrl bit 2", readData[7:4], 32'h4);
    readStrobe = 1; step(1); readStrobe = 0;
    ctrlBits = 4'b0010;
    step(1);
    chk("R6 ctrl bit 2 fall sets bit 2, R5 ctrl bit 1 to line bit 4", readData, 32'h15);
    ctrlBits = 4'b1001;
    step(1);
    phaseTag = "R1,R2,R3,R5,R6";
    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) pinCarrierN = ~pinCarrierN;
      if ($urandom_range(0, 7) == 0) pinRingN = ~pinRingN;
      if ($urandom_range(0, 7) == 0) pinReadyN = ~pinReadyN;
      if ($urandom_range(0, 7) == 0) pinClearN = ~pinClearN;
      if ($urandom_range(0, 31) == 0) loopEn = ~loopEn;
      if ($urandom_range(0, 3) == 0) ctrlBits = 4'($urandom);
      readStrobe = ($urandom_range(0, 3) == 0);
      intEnable = ($urandom_range(0, 1) == 0);
      step(1);
    end
    finish();
  end
endmodule